// File: doc/BRIEF.md
# Oversampled Serial Line Receiver

This block recovers framed data from an asynchronous serial line. A free-running local clock runs at four times the bit rate. The line first passes through a two-stage synchronizer. Every transition of the synchronized line restarts a 2-bit sample-phase counter, so each sample falls near the middle of a bit (or half-bit). Recovered bits are shifted into a frame register of `FRAME_BITS` bits, 50 by default.

A mode input selects the line code. In plain NRZ mode each bit lasts four clock ticks. In Manchester mode each half-bit lasts four ticks, so the data rate is half the NRZ rate at the same clock. A frame ends when the line stays quiet for more than three bit times. A one-cycle valid strobe then reports a frame of exactly the expected length. A one-cycle code-error strobe reports a Manchester bit that has no mid-bit transition, and that frame is dropped.

Top module: `osr_rx`

## Requirements
- R1: The serial input reaches the decision logic through two flip-flops. Each transition of the synchronized line restarts the phase count, and the next sample is taken two ticks after that transition. Bits that are 3 or 5 ticks wide are therefore recovered correctly, provided each bit is bounded by transitions.
- R2: NRZ mode (`i_mode`=0) uses four ticks per bit. The line idles low. A frame is a start bit of 1, then `FRAME_BITS` data bits, then a stop bit of 1. The first data bit received ends up in `o_frame[FRAME_BITS-1]` and the last in `o_frame[0]`.
- R3: Manchester mode (`i_mode`=1) uses four ticks per half-bit. A 1 is sent as high then low, and a 0 as low then high. A frame is a start bit of 1 followed by `FRAME_BITS` data bits, with no stop bit.
- R4: After a complete frame, `o_valid` is high for exactly one cycle, and `o_frame` holds the data bits while `o_valid` is high.
- R5: A frame ends when the line has no transition for more than three bit times. That is 13 ticks in NRZ mode and 25 ticks in Manchester mode. `o_valid` rises 16 cycles (NRZ) or 28 cycles (Manchester) after the last change of `i_rx`.
- R6: A frame with fewer than `FRAME_BITS` data bits produces no `o_valid`.
- R7: A frame with more than `FRAME_BITS` data bits produces no `o_valid` and, in Manchester mode, no `o_code_err`.
- R8: In Manchester mode, a bit whose two halves are equal raises `o_code_err` for one cycle. That frame then produces no `o_valid`.
- R9: In NRZ mode, a frame whose stop-bit position holds 0 produces no `o_valid`.
- R10: In NRZ mode, a run of four or more equal bits inside a frame triggers the quiet timeout. The frame is discarded without `o_valid` and without `o_code_err`.
- R11: Synchronous reset drives `o_valid`, `o_code_err` and `o_frame` to 0 and abandons any partial frame. A complete frame after reset is received normally.
- R12: `o_code_err` never rises while NRZ mode is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_clk | input | 1 | Oversampling clock, four ticks per line symbol |
| i_rst | input | 1 | Synchronous active-high reset |
| i_rx | input | 1 | Asynchronous serial line |
| i_mode | input | 1 | 0 selects NRZ, 1 selects Manchester |
| o_valid | output | 1 | One-cycle strobe for a complete frame |
| o_frame | output | FRAME_BITS | Recovered frame, first bit in the MSB |
| o_code_err | output | 1 | One-cycle strobe for a Manchester bit without a mid-bit transition |

## Verification
A change on `i_rx` reaches the edge detector two cycles later. The mid-symbol sample follows two ticks after that, and a code error is flagged one cycle after the second-half sample that exposes it. The valid strobe is due exactly 16 cycles (NRZ) or 28 cycles (Manchester) after the final line change. The bench records the clock count of every change it drives and of every strobe it sees, and compares the difference with these figures. Outputs are sampled on the falling clock edge, and strobes are counted over an idle window that is much longer than the quiet timeout, so that a missing pulse, an extra pulse or a late pulse is each caught.

// File: rtl/osr_rx_pkg.sv
package osr_rx_pkg;

    // Oversampling ratio is fixed by the 2-bit sample-phase counter.
    localparam int unsigned OSR  = 4;
    localparam int unsigned PH_W = $clog2(OSR);
    localparam logic [PH_W-1:0] MID_PHASE = PH_W'(OSR / 2 - 1);

    typedef enum logic {
        MODE_NRZ = 1'b0,
        MODE_MAN = 1'b1
    } line_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_TAIL,
        ST_DRAIN
    } rx_state_e;

    // One mid-symbol sample of the synchronized line.
    typedef struct packed {
        logic stb;
        logic val;
    } sample_t;

    // One decoded data bit, with a line-code violation marker.
    typedef struct packed {
        logic stb;
        logic val;
        logic bad;
    } dbit_t;

    // Ticks without a transition that end a frame (strictly more than idle_bits bit times).
    function automatic int unsigned quiet_limit(input logic man, input int unsigned idle_bits);
        return idle_bits * OSR * (man ? 2 : 1) + 1;
    endfunction

endpackage

// File: rtl/osr_rx_sync.sv
module osr_rx_sync (
    input  logic i_clk,
    input  logic i_rst,
    input  logic i_rx,
    output logic o_line,
    output logic o_edge
);
    // Stages 0 and 1 form the synchronizer; stage 2 keeps the previous value for edge detection.
    logic [2:0] stage;

    always_ff @(posedge i_clk) begin
        if (i_rst) stage <= '0;
        else       stage <= {stage[1:0], i_rx};
    end

    assign o_line = stage[1];
    assign o_edge = stage[1] ^ stage[2];
endmodule

// File: rtl/osr_rx_slicer.sv
module osr_rx_slicer
    import osr_rx_pkg::*;
(
    input  logic    i_clk,
    input  logic    i_rst,
    input  logic    i_line,
    input  logic    i_edge,
    output sample_t o_smp
);
    logic [PH_W-1:0] phase;

    // Every transition restarts the count, so the sample lands mid-symbol.
    always_ff @(posedge i_clk) begin
        if (i_rst)       phase <= '0;
        else if (i_edge) phase <= '0;
        else             phase <= phase + 1'b1;
    end

    always_comb begin
        o_smp.stb = (phase == MID_PHASE);
        o_smp.val = i_line;
    end

    // R1: an isolated transition is followed by a sample exactly two ticks later
    a_r1_mid_sample: assert property (@(posedge i_clk) disable iff (i_rst)
        (i_edge ##1 !i_edge) |=> o_smp.stb);

    // R1: no sample is taken on the tick right after a transition
    a_r1_no_early_sample: assert property (@(posedge i_clk) disable iff (i_rst)
        i_edge |=> !o_smp.stb);
endmodule

// File: rtl/osr_rx_decoder.sv
module osr_rx_decoder
    import osr_rx_pkg::*;
(
    input  logic       i_clk,
    input  logic       i_rst,
    input  line_mode_e i_mode,
    input  logic       i_align,
    input  sample_t    i_smp,
    output dbit_t      o_bit
);
    logic half;   // a first half-bit is held
    logic first;  // value of that first half

    always_ff @(posedge i_clk) begin
        if (i_rst || i_mode == MODE_NRZ) begin
            half  <= 1'b0;
            first <= 1'b0;
        end else if (i_smp.stb) begin
            if (!half) begin
                // While hunting for a start bit, only a high first half opens a pair.
                if (!i_align || i_smp.val) begin
                    half  <= 1'b1;
                    first <= i_smp.val;
                end
            end else begin
                half <= 1'b0;
            end
        end
    end

    always_comb begin
        o_bit = '0;
        if (i_mode == MODE_NRZ) begin
            o_bit.stb = i_smp.stb;
            o_bit.val = i_smp.val;
        end else if (i_smp.stb && half && (!i_align || first)) begin
            o_bit.stb = 1'b1;
            o_bit.val = first;
            o_bit.bad = (first == i_smp.val);
        end
    end
endmodule

// File: rtl/osr_rx_framer.sv
module osr_rx_framer
    import osr_rx_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 50,
    parameter int unsigned IDLE_BITS  = 3
) (
    input  logic                  i_clk,
    input  logic                  i_rst,
    input  line_mode_e            i_mode,
    input  logic                  i_edge,
    input  sample_t               i_smp,
    input  dbit_t                 i_bit,
    output logic                  o_align,
    output logic                  o_valid,
    output logic                  o_code_err,
    output logic [FRAME_BITS-1:0] o_frame
);
    localparam int unsigned LIM_NRZ = quiet_limit(1'b0, IDLE_BITS);
    localparam int unsigned LIM_MAN = quiet_limit(1'b1, IDLE_BITS);
    localparam int unsigned QW      = $clog2(LIM_MAN + 1);
    localparam int unsigned CW      = $clog2(FRAME_BITS + 1);
    localparam logic [CW-1:0] LAST  = CW'(FRAME_BITS - 1);
    localparam logic [CW-1:0] FULL  = CW'(FRAME_BITS);

    rx_state_e       state;
    logic [CW-1:0]   cnt;
    logic [QW-1:0]   quiet;
    logic [QW-1:0]   lim;
    logic            timeout;

    assign lim     = (i_mode == MODE_MAN) ? QW'(LIM_MAN) : QW'(LIM_NRZ);
    assign timeout = (quiet >= lim);
    assign o_align = (state == ST_IDLE);

    // Ticks since the last transition, saturating at the longer limit.
    always_ff @(posedge i_clk) begin
        if (i_rst)                    quiet <= '0;
        else if (i_edge)              quiet <= QW'(1);
        else if (quiet != QW'(LIM_MAN)) quiet <= quiet + 1'b1;
    end

    always_ff @(posedge i_clk) begin
        if (i_rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            o_frame    <= '0;
            o_valid    <= 1'b0;
            o_code_err <= 1'b0;
        end else begin
            o_valid    <= 1'b0;
            o_code_err <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (i_bit.stb && i_bit.bad) begin
                        o_code_err <= 1'b1;
                        state      <= ST_DRAIN;
                    end else if (i_bit.stb && i_bit.val) begin
                        cnt   <= '0;
                        state <= ST_RECV;
                    end
                end
                ST_RECV: begin
                    if (i_bit.stb && i_bit.bad) begin
                        o_code_err <= 1'b1;
                        state      <= ST_DRAIN;
                    end else if (timeout) begin
                        state <= ST_IDLE;
                    end else if (i_bit.stb) begin
                        if (cnt < FULL) begin
                            o_frame <= {o_frame[FRAME_BITS-2:0], i_bit.val};
                            cnt     <= cnt + 1'b1;
                            if (i_mode == MODE_MAN && cnt == LAST) state <= ST_TAIL;
                        end else begin
                            // NRZ stop-bit position
                            state <= i_bit.val ? ST_TAIL : ST_DRAIN;
                        end
                    end
                end
                ST_TAIL: begin
                    if (timeout) begin
                        o_valid <= 1'b1;
                        state   <= ST_IDLE;
                    end else if (i_smp.stb && i_smp.val) begin
                        state <= ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (timeout) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: the bit count never runs past the frame length
    a_r6_count_bound: assert property (@(posedge i_clk) disable iff (i_rst)
        cnt <= FULL);

    // R4: the valid strobe lasts one cycle
    a_r4_valid_pulse: assert property (@(posedge i_clk) disable iff (i_rst)
        o_valid |=> !o_valid);

    // R8: the code-error strobe lasts one cycle
    a_r8_err_pulse: assert property (@(posedge i_clk) disable iff (i_rst)
        o_code_err |=> !o_code_err);

    // R5: a frame is only reported after the line has been quiet long enough
    a_r5_quiet_before_valid: assert property (@(posedge i_clk) disable iff (i_rst)
        o_valid |-> ($past(quiet) >= QW'(LIM_NRZ)));
endmodule

// File: rtl/osr_rx.sv
module osr_rx
    import osr_rx_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 50,
    parameter int unsigned IDLE_BITS  = 3
) (
    input  logic                  i_clk,
    input  logic                  i_rst,
    input  logic                  i_rx,
    input  logic                  i_mode,
    output logic                  o_valid,
    output logic [FRAME_BITS-1:0] o_frame,
    output logic                  o_code_err
);
    line_mode_e mode;
    logic       line;
    logic       edge_s;
    logic       align;
    sample_t    smp;
    dbit_t      dbit;

    assign mode = line_mode_e'(i_mode);

    osr_rx_sync u_sync (
        .i_clk  (i_clk),
        .i_rst  (i_rst),
        .i_rx   (i_rx),
        .o_line (line),
        .o_edge (edge_s)
    );

    osr_rx_slicer u_slicer (
        .i_clk  (i_clk),
        .i_rst  (i_rst),
        .i_line (line),
        .i_edge (edge_s),
        .o_smp  (smp)
    );

    osr_rx_decoder u_dec (
        .i_clk   (i_clk),
        .i_rst   (i_rst),
        .i_mode  (mode),
        .i_align (align),
        .i_smp   (smp),
        .o_bit   (dbit)
    );

    osr_rx_framer #(
        .FRAME_BITS (FRAME_BITS),
        .IDLE_BITS  (IDLE_BITS)
    ) u_framer (
        .i_clk      (i_clk),
        .i_rst      (i_rst),
        .i_mode     (mode),
        .i_edge     (edge_s),
        .i_smp      (smp),
        .i_bit      (dbit),
        .o_align    (align),
        .o_valid    (o_valid),
        .o_code_err (o_code_err),
        .o_frame    (o_frame)
    );

    // R12: no code error while NRZ mode is held
    a_r12_no_err_in_nrz: assert property (@(posedge i_clk) disable iff (i_rst)
        (!i_mode && $past(!i_mode)) |-> !o_code_err);
endmodule

// File: tb/sim_osr_rx.sv
module sim_osr_rx;
    localparam int CLK_PERIOD = 10;
    localparam int FB         = 50;
    localparam int NRZ_LAT    = 16;
    localparam int MAN_LAT    = 28;
    localparam int IDLE_TICKS = 320;
    localparam int WATCHDOG   = 150000;

    typedef struct packed {
        logic        mode;
        logic [63:0] data;
        logic [7:0]  nbits;
        logic        stop;
        logic [7:0]  badk;
        logic        jit;
        logic        exp_v;
        logic        exp_e;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 64'hAAAAAAAAAAAAAAAA, 8'd50, 1'b1, 8'hFF, 1'b0, 1'b1, 1'b0},
        '{1'b0, 64'h6DB6DB6DB6DB6DB6, 8'd50, 1'b1, 8'hFF, 1'b0, 1'b1, 1'b0},
        '{1'b0, 64'h8888888888888888, 8'd50, 1'b1, 8'hFF, 1'b0, 1'b1, 1'b0},
        '{1'b0, 64'hEEEEEEEEEEEEEEEE, 8'd50, 1'b1, 8'hFF, 1'b0, 1'b1, 1'b0},
        '{1'b0, 64'hAAAAAAAAAAAAAAAA, 8'd50, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b0},
        '{1'b0, 64'hAAAAAAAAAAAAAAAA, 8'd49, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0},
        '{1'b0, 64'hAAAAAAAAAAAAAAAA, 8'd51, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0},
        '{1'b0, 64'hAAAAAAAAAAAAAAAA, 8'd50, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0},
        '{1'b0, 64'hF0F0F0F0F0F0F0F0, 8'd50, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0},
        '{1'b1, 64'hAAAAAAAAAAAAAAAA, 8'd50, 1'b0, 8'hFF, 1'b0, 1'b1, 1'b0},
        '{1'b1, 64'h0000000000000000, 8'd50, 1'b0, 8'hFF, 1'b0, 1'b1, 1'b0},
        '{1'b1, 64'hFFFFFFFFFFFFFFFF, 8'd50, 1'b0, 8'hFF, 1'b0, 1'b1, 1'b0},
        '{1'b1, 64'h6DB6DB6DB6DB6DB6, 8'd50, 1'b0, 8'd10, 1'b0, 1'b0, 1'b1},
        '{1'b1, 64'hAAAAAAAAAAAAAAAA, 8'd49, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b1},
        '{1'b1, 64'hAAAAAAAAAAAAAAAA, 8'd51, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rx  = 1'b0;
    logic          mode = 1'b0;
    logic          o_valid;
    logic          o_code_err;
    logic [FB-1:0] o_frame;

    int            cyc = 0;
    int            last_chg = 0;
    int            nvalid = 0;
    int            nerr = 0;
    int            vcyc = 0;
    logic [FB-1:0] vframe = '0;
    int            checks = 0;
    int            errors = 0;

    osr_rx #(.FRAME_BITS(FB), .IDLE_BITS(3)) u0 (
        .i_clk      (clk),
        .i_rst      (rst),
        .i_rx       (rx),
        .i_mode     (mode),
        .o_valid    (o_valid),
        .o_frame    (o_frame),
        .o_code_err (o_code_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Strobe monitor, away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (o_valid) begin
                nvalid = nvalid + 1;
                vcyc   = cyc;
                vframe = o_frame;
            end
            if (o_code_err) nerr = nerr + 1;
        end
    end

    always @(posedge clk) begin
        if (cyc > WATCHDOG) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive_level(input logic v, input int ticks);
        for (int t = 0; t < ticks; t++) begin
            @(negedge clk);
            if (rx !== v) last_chg = cyc;
            rx = v;
        end
    endtask

    task automatic send_frame(input logic m, input logic [63:0] d, input int nb,
                              input logic stp, input int badk, input logic jit);
        logic b;
        int   w;
        mode = m;
        drive_level(1'b0, 8);
        if (!m) begin
            drive_level(1'b1, 4);
            for (int k = 0; k < nb; k++) begin
                b = (k < FB) ? d[FB-1-k] : 1'b1;
                w = jit ? ((k % 2 == 1) ? 5 : 3) : 4;
                drive_level(b, w);
            end
            if (stp) drive_level(1'b1, 4);
        end else begin
            drive_level(1'b1, 4);
            drive_level(1'b0, 4);
            for (int k = 0; k < nb; k++) begin
                b = (k < FB) ? d[FB-1-k] : 1'b1;
                if (k == badk) drive_level(b, 8);
                else begin
                    drive_level(b, 4);
                    drive_level(~b, 4);
                end
            end
        end
        drive_level(1'b0, IDLE_TICKS);
    endtask

    function automatic string tag_of(input int i);
        case (i)
            0, 1, 2, 3: return "R2";
            4:          return "R1";
            5, 13:      return "R6";
            6, 14:      return "R7";
            7:          return "R9";
            8:          return "R10";
            12:         return "R8";
            default:    return "R3";
        endcase
    endfunction

    initial begin
        int v0;
        int e0;
        logic [63:0] mask;
        mask = (64'd1 << FB) - 64'd1;

        repeat (5) @(negedge clk);
        // R11: state right after reset
        rst = 1'b0;
        @(negedge clk);
        check(o_valid == 1'b0, "R11", "valid after reset", 64'(o_valid), 64'd0);
        check(o_code_err == 1'b0, "R11", "code_err after reset", 64'(o_code_err), 64'd0);
        check(o_frame == '0, "R11", "frame after reset", 64'(o_frame), 64'd0);
        drive_level(1'b0, 40);

        // Table of frames walked by one loop.
        for (int i = 0; i < NV; i++) begin
            v0 = nvalid;
            e0 = nerr;
            send_frame(VECS[i].mode, VECS[i].data, int'(VECS[i].nbits), VECS[i].stop,
                       (VECS[i].badk == 8'hFF) ? -1 : int'(VECS[i].badk), VECS[i].jit);
            check((nvalid - v0) == int'(VECS[i].exp_v), tag_of(i), "valid count R4",
                  64'(nvalid - v0), 64'(VECS[i].exp_v));
            check((nerr - e0) == int'(VECS[i].exp_e), VECS[i].mode ? tag_of(i) : "R12",
                  "code_err count", 64'(nerr - e0), 64'(VECS[i].exp_e));
            if (VECS[i].exp_v) begin
                check(64'(vframe) == (VECS[i].data & mask), tag_of(i), "frame content R4",
                      64'(vframe), VECS[i].data & mask);
                check((vcyc - last_chg) == (VECS[i].mode ? MAN_LAT : NRZ_LAT), "R5",
                      "valid latency", 64'(vcyc - last_chg),
                      64'(VECS[i].mode ? MAN_LAT : NRZ_LAT));
            end
        end

        // R11: reset in the middle of a frame
        mode = 1'b0;
        drive_level(1'b1, 4);
        for (int k = 0; k < 20; k++) drive_level((k % 2 == 0), 4);
        @(negedge clk);
        rst = 1'b1;
        rx  = 1'b0;
        repeat (3) @(negedge clk);
        check(o_frame == '0, "R11", "frame cleared by reset", 64'(o_frame), 64'd0);
        check(o_valid == 1'b0, "R11", "valid during reset", 64'(o_valid), 64'd0);
        rst = 1'b0;
        drive_level(1'b0, 100);
        v0 = nvalid;
        send_frame(1'b0, 64'h6DB6DB6DB6DB6DB6, FB, 1'b1, -1, 1'b0);
        check((nvalid - v0) == 1, "R11", "frame after reset valid", 64'(nvalid - v0), 64'd1);
        check(64'(vframe) == (64'h6DB6DB6DB6DB6DB6 & mask), "R11", "frame after reset data",
              64'(vframe), 64'h6DB6DB6DB6DB6DB6 & mask);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule